// File: doc/BRIEF.md
# Multiplexed-Address DRAM Access Sequencer

This block turns a single host memory request into the strobe sequence that an asynchronous DRAM with a shared row/column address bus expects. The host presents a word address, a write word, a direction bit and a one-cycle start strobe. The block latches them and puts the row half of the address on the bus. It drops the row strobe, swaps in the column half and drops the column strobe. It then waits out the access window and releases every strobe together. Completion is reported by a one-clock done pulse. For a read, the captured word is already in the data register when that pulse appears.

Every timing window is counted in whole clock cycles and set by a parameter: row setup, row hold, column setup, column hold, access time and minimum cycle time. A per-request input selects where the output-enable falls on reads. In the early ordering it falls together with the row strobe. In the late ordering it falls one cycle after the column strobe. The late ordering stretches the strobe phase so that the access window is still met from the output-enable edge. The host side is a plain strobe/pulse handshake with no back-pressure. A start that arrives while a sequence runs, or before the cycle-time window has passed, is dropped, so the host waits for the done pulse before it issues the next request.

Top module: `adram_ctrl`

## Requirements
- R1: After reset, the row strobe, column strobe, output enable and write enable (all active low) are high, the done pulse is low and the data bus is not driven.
- R2: The row is bits [ADDR_W-1:COL_W] of the latched address and the column is bits [COL_W-1:0]. Both are zero-extended onto the shared bus. rw=1 requests a read and rw=0 a write. The request fields are latched on the accepting edge and may change afterwards.
- R3: The row is on the bus for T_RSU cycles before the row strobe falls and stays there for T_RH cycles after it. The column strobe stays high during that time.
- R4: The column is on the bus for T_CSU cycles before the column strobe falls and stays stable while the column strobe is low. The column strobe is only ever low while the row strobe is low.
- R5: On an early read (late_rd=0), the output enable falls in the same cycle as the row strobe, before the column reaches the bus.
- R6: On a late read (late_rd=1), the output enable falls exactly one cycle after the column strobe.
- R7: The column strobe stays low for max(T_CH,T_ACC) cycles on an early read or write, and for max(T_CH,T_ACC+1) cycles on a late read. A read captures dq_in on the last of those edges into mdr_out. The done pulse is high for exactly the following cycle.
- R8: On a write, the write enable is low and dq_out carries the latched write word from the cycle the row strobe falls until the strobes are released. The output enable never falls during a write.
- R9: A start is ignored while a sequence runs. It is also ignored on any edge fewer than T_CYC edges after the previous accepting edge. It is accepted on the T_CYC-th edge.
- R10: In the cycle the done pulse is high, all four strobes are high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request strobe |
| rw | input | 1 | 1 = read, 0 = write |
| late_rd | input | 1 | Read output-enable ordering: 0 early, 1 late |
| mar | input | ADDR_W | Word address |
| mdr_in | input | DATA_W | Write word |
| mfc | output | 1 | One-cycle completion pulse |
| mdr_out | output | DATA_W | Last word read |
| dram_addr | output | max(ROW_W,COL_W) | Multiplexed row/column bus |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| oe_n | output | 1 | Output enable, active low |
| we_n | output | 1 | Write enable, active low |
| dq_out | output | DATA_W | Write data to the DRAM |
| dq_drive | output | 1 | High while dq_out should drive the bus |
| dq_in | input | DATA_W | Read data from the DRAM |

## Verification
The hardest situation to reach is the edge of the cycle-time window. The stimulus has to place a start exactly one edge before the T_CYC-th edge after the previous acceptance, and then exactly on it. A start that is wrongly accepted shows only as a shifted strobe trace. The bench keeps its own count of clock edges since each acceptance. It pulses start on the last forbidden edge and launches a full access on the first allowed one. It also pokes start in the middle of a running sequence. The DRAM model returns junk until its output-enable and column strobe have both been low long enough, so a strobe phase that is one cycle short returns a wrong word.

// File: rtl/adram_pkg.sv
package adram_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_RSU,
    PH_RH,
    PH_CSU,
    PH_STRB
  } phase_t;
endpackage

// File: rtl/adram_phase_timer.sv
module adram_phase_timer #(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          done
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/adram_gap_guard.sv
module adram_gap_guard #(
  parameter int T_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  output logic ok
);
  localparam int GW = $clog2(T_CYC + 1);
  logic [GW-1:0] since;

  always_ff @(posedge clk) begin
    if (!rst_n)                    since <= GW'(T_CYC);
    else if (take)                 since <= GW'(1);
    else if (since < GW'(T_CYC))   since <= since + 1'b1;
  end

  assign ok = (since >= GW'(T_CYC));

  // R9: an acceptance restarts the window from one edge
  assert_gap_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (since == GW'(1) || T_CYC == 1));
endmodule

// File: rtl/adram_addr_split.sv
module adram_addr_split #(
  parameter int ADDR_W = 8,
  parameter int ROW_W  = 4,
  parameter int BUS_W  = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              sel_col,
  output logic [BUS_W-1:0]  bus
);
  localparam int COL_W = ADDR_W - ROW_W;
  logic [BUS_W-1:0] row_ext, col_ext;

  always_comb begin
    row_ext = '0;
    col_ext = '0;
    row_ext[ROW_W-1:0] = addr[ADDR_W-1:COL_W];
    col_ext[COL_W-1:0] = addr[COL_W-1:0];
    bus = sel_col ? col_ext : row_ext;
  end
endmodule

// File: rtl/adram_ctrl.sv
module adram_ctrl
  import adram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int ROW_W  = 4,
  parameter int T_RSU  = 2,
  parameter int T_RH   = 1,
  parameter int T_CSU  = 2,
  parameter int T_CH   = 2,
  parameter int T_ACC  = 3,
  parameter int T_CYC  = 14,
  localparam int COL_W = ADDR_W - ROW_W,
  localparam int BUS_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              rw,
  input  logic              late_rd,
  input  logic [ADDR_W-1:0] mar,
  input  logic [DATA_W-1:0] mdr_in,
  output logic              mfc,
  output logic [DATA_W-1:0] mdr_out,
  output logic [BUS_W-1:0]  dram_addr,
  output logic              ras_n,
  output logic              cas_n,
  output logic              oe_n,
  output logic              we_n,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_drive,
  input  logic [DATA_W-1:0] dq_in
);
  localparam int LEN_E = (T_CH > T_ACC) ? T_CH : T_ACC;
  localparam int LEN_L = (T_CH > T_ACC + 1) ? T_CH : T_ACC + 1;
  localparam int M1    = (T_RSU > T_RH) ? T_RSU : T_RH;
  localparam int M2    = (T_CSU > LEN_L) ? T_CSU : LEN_L;
  localparam int MAXC  = (M1 > M2) ? M1 : M2;
  localparam int CW    = $clog2(MAXC + 1);

  phase_t            ph;
  logic              rd_q, late_q, strb_first, mfc_q;
  logic [ADDR_W-1:0] mar_q;
  logic [DATA_W-1:0] wd_q, mdr_q;
  logic              tm_load, tm_done, gap_ok, take;
  logic [CW-1:0]     tm_val;
  logic              ras_on, cas_on, sel_col;

  assign take = start && (ph == PH_IDLE) && gap_ok;

  adram_phase_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tm_load), .load_val(tm_val), .done(tm_done)
  );

  adram_gap_guard #(.T_CYC(T_CYC)) u_gap (
    .clk(clk), .rst_n(rst_n), .take(take), .ok(gap_ok)
  );

  adram_addr_split #(.ADDR_W(ADDR_W), .ROW_W(ROW_W), .BUS_W(BUS_W)) u_split (
    .addr(mar_q), .sel_col(sel_col), .bus(dram_addr)
  );

  always_comb begin
    tm_load = 1'b0;
    tm_val  = '0;
    case (ph)
      PH_IDLE: if (take)    begin tm_load = 1'b1; tm_val = CW'(T_RSU - 1); end
      PH_RSU:  if (tm_done) begin tm_load = 1'b1; tm_val = CW'(T_RH - 1);  end
      PH_RH:   if (tm_done) begin tm_load = 1'b1; tm_val = CW'(T_CSU - 1); end
      PH_CSU:  if (tm_done) begin
        tm_load = 1'b1;
        tm_val  = (rd_q && late_q) ? CW'(LEN_L - 1) : CW'(LEN_E - 1);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph         <= PH_IDLE;
      rd_q       <= 1'b1;
      late_q     <= 1'b0;
      strb_first <= 1'b0;
      mfc_q      <= 1'b0;
      mar_q      <= '0;
      wd_q       <= '0;
      mdr_q      <= '0;
    end else begin
      mfc_q      <= 1'b0;
      strb_first <= 1'b0;
      case (ph)
        PH_IDLE: if (take) begin
          ph     <= PH_RSU;
          rd_q   <= rw;
          late_q <= late_rd;
          mar_q  <= mar;
          wd_q   <= mdr_in;
        end
        PH_RSU: if (tm_done) ph <= PH_RH;
        PH_RH:  if (tm_done) ph <= PH_CSU;
        PH_CSU: if (tm_done) begin
          ph         <= PH_STRB;
          strb_first <= 1'b1;
        end
        PH_STRB: if (tm_done) begin
          ph    <= PH_IDLE;
          mfc_q <= 1'b1;
          if (rd_q) mdr_q <= dq_in;
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

  assign ras_on   = (ph == PH_RH) || (ph == PH_CSU) || (ph == PH_STRB);
  assign cas_on   = (ph == PH_STRB);
  assign sel_col  = (ph == PH_CSU) || (ph == PH_STRB);
  assign ras_n    = !ras_on;
  assign cas_n    = !cas_on;
  assign oe_n     = !(rd_q && (late_q ? (cas_on && !strb_first) : ras_on));
  assign we_n     = !(!rd_q && ras_on);
  assign dq_drive = !rd_q && ras_on;
  assign dq_out   = wd_q;
  assign mfc      = mfc_q;
  assign mdr_out  = mdr_q;

  assert_ras_addr_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> $stable(dram_addr));
  assert_cas_inside_ras_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_n |-> !ras_n);
  assert_col_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cas_n && $past(!cas_n)) |-> $stable(dram_addr));
  assert_late_oe_after_cas_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(oe_n) && late_q) |-> $past(!cas_n));
  assert_write_no_oe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> oe_n);
  assert_mfc_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mfc |=> !mfc);
  assert_mfc_released_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mfc |-> (ras_n && cas_n && oe_n && we_n));
endmodule

// File: tb/sim_adram_ctrl.sv
module sim_adram_ctrl;
  localparam int ADDR_W = 8, DATA_W = 8, ROW_W = 4, COL_W = 4;
  localparam int T_RSU = 2, T_RH = 1, T_CSU = 2, T_CH = 2, T_ACC = 3, T_CYC = 14;
  localparam int LEN_E = (T_CH > T_ACC) ? T_CH : T_ACC;
  localparam int LEN_L = (T_CH > T_ACC + 1) ? T_CH : T_ACC + 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, rw = 1'b1, late_rd = 1'b0;
  logic [ADDR_W-1:0] mar = '0;
  logic [DATA_W-1:0] mdr_in = '0, mdr_out, dq_out, dq_in;
  logic [3:0] dram_addr;
  logic mfc, ras_n, cas_n, oe_n, we_n, dq_drive;

  always #10 clk = ~clk;

  adram_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ROW_W(ROW_W), .T_RSU(T_RSU),
    .T_RH(T_RH), .T_CSU(T_CSU), .T_CH(T_CH), .T_ACC(T_ACC), .T_CYC(T_CYC)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .rw(rw), .late_rd(late_rd), .mar(mar),
    .mdr_in(mdr_in), .mfc(mfc), .mdr_out(mdr_out), .dram_addr(dram_addr),
    .ras_n(ras_n), .cas_n(cas_n), .oe_n(oe_n), .we_n(we_n), .dq_out(dq_out),
    .dq_drive(dq_drive), .dq_in(dq_in));

  // DRAM model: returns junk until OE and CAS have been low for the access time
  logic [7:0] dmem [256];
  logic [7:0] ref_mem [256];
  logic [3:0] row_l = '0, col_l = '0;
  int acc_cnt = 0;
  always @(negedge ras_n) row_l = dram_addr;
  always @(negedge cas_n) col_l = dram_addr;
  always @(posedge clk) begin
    if (!cas_n && !oe_n) acc_cnt <= acc_cnt + 1; else acc_cnt <= 0;
    if (!cas_n && !we_n && dq_drive) dmem[{row_l, col_l}] <= dq_out;
  end
  assign dq_in = (acc_cnt >= T_ACC - 1) ? dmem[{row_l, col_l}] : 8'hEE;

  int total = 0, fails = 0, pe = 0, pe_acc = -100;
  always @(posedge clk) pe <= pe + 1;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // scoreboard
  typedef struct { bit rd; logic [7:0] a; logic [7:0] d; } item_t;
  item_t q[$];
  always @(negedge clk) begin
    if (rst_n && mfc) begin
      if (q.size() == 0) chk(1'b0, "R7", "done pulse with nothing pending", 1, 0);
      else begin
        item_t it;
        it = q.pop_front();
        if (it.rd) chk(mdr_out == it.d, "R7", "read word", int'(mdr_out), int'(it.d));
        else       chk(dmem[it.a] == it.d, "R8", "written word", int'(dmem[it.a]), int'(it.d));
      end
    end
  end

  logic s_ras [64], s_cas [64], s_oe [64], s_we [64], s_drv [64];
  logic [3:0] s_addr [64];
  logic [7:0] s_dq [64];

  task automatic wait_gap(input int m);
    while (pe + 1 - pe_acc < m) @(negedge clk);
  endtask

  // call at a negedge; start is sampled on the following posedge
  task automatic access(input bit rd, input bit late, input logic [7:0] a, input logic [7:0] wd, input bit poke);
    item_t it;
    int n, ir, ic, io, iw, len;
    bit ok;
    start = 1'b1; rw = rd; late_rd = late; mar = a; mdr_in = wd;
    if (!rd) ref_mem[a] = wd;
    it.rd = rd; it.a = a; it.d = ref_mem[a];
    q.push_back(it);
    @(negedge clk);
    start = 1'b0; pe_acc = pe; rw = ~rd; mar = ~a; mdr_in = ~wd; late_rd = ~late;
    n = 0;
    forever begin
      s_ras[n] = ras_n; s_cas[n] = cas_n; s_oe[n] = oe_n; s_we[n] = we_n;
      s_drv[n] = dq_drive; s_addr[n] = dram_addr; s_dq[n] = dq_out;
      if (mfc || n == 40) break;
      start = (poke && n == 3);
      @(negedge clk);
      n++;
    end
    start = 1'b0;
    ir = -1; ic = -1; io = -1; iw = -1;
    for (int i = n; i >= 0; i--) begin
      if (!s_ras[i]) ir = i;
      if (!s_cas[i]) ic = i;
      if (!s_oe[i])  io = i;
      if (!s_we[i])  iw = i;
    end
    len = (rd && late) ? LEN_L : LEN_E;
    chk(ir == T_RSU, "R3", "row strobe fall index", ir, T_RSU);
    ok = 1'b1;
    for (int i = 0; i < T_RSU + T_RH; i++) if (s_addr[i] != a[7:4] || !s_cas[i]) ok = 1'b0;
    chk(ok, "R3", "row held around row strobe (R2 row field)", int'(s_addr[T_RSU]), int'(a[7:4]));
    chk(ic == T_RSU + T_RH + T_CSU, "R4", "column strobe fall index", ic, T_RSU + T_RH + T_CSU);
    ok = 1'b1;
    for (int i = T_RSU + T_RH; i < n; i++) if (s_addr[i] != a[3:0]) ok = 1'b0;
    chk(ok, "R4", "column held (R2 column field)", int'(s_addr[n-1]), int'(a[3:0]));
    chk(n == ic + len, "R7", "done pulse index", n, ic + len);
    chk(s_ras[n] && s_cas[n] && s_oe[n] && s_we[n], "R10", "strobes released at done",
        int'({s_ras[n], s_cas[n], s_oe[n], s_we[n]}), 15);
    if (rd && !late) chk(io == ir, "R5", "early output enable index", io, ir);
    if (rd && late)  chk(io == ic + 1, "R6", "late output enable index", io, ic + 1);
    if (!rd) begin
      chk(io == -1, "R8", "output enable during write", io, -1);
      ok = 1'b1;
      for (int i = ir; i < n; i++) if (s_we[i] || !s_drv[i] || s_dq[i] != wd) ok = 1'b0;
      chk(ok && iw == ir, "R8", "write enable and data from row strobe", iw, ir);
    end
    @(negedge clk);
    chk(!mfc, "R7", "done pulse one cycle", int'(mfc), 0);
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 20000) begin @(posedge clk); cyc++; end
    chk(1'b0, "watchdog", "run did not finish", cyc, 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin dmem[i] = 8'(i) ^ 8'h5A; ref_mem[i] = 8'(i) ^ 8'h5A; end
    repeat (3) @(negedge clk);
    chk(ras_n && cas_n && oe_n && we_n && !mfc && !dq_drive, "R1", "reset outputs",
        int'({ras_n, cas_n, oe_n, we_n, mfc, dq_drive}), 6'b111100);
    rst_n = 1'b1;
    @(negedge clk);
    access(1'b0, 1'b0, 8'h3C, 8'hA5, 1'b0);          // R8 write
    wait_gap(T_CYC); access(1'b1, 1'b0, 8'h3C, 8'h00, 1'b0);  // R5 early read
    wait_gap(T_CYC); access(1'b1, 1'b1, 8'h3C, 8'h00, 1'b0);  // R6 late read
    wait_gap(T_CYC); access(1'b1, 1'b0, 8'hC1, 8'h00, 1'b0);  // untouched word
    wait_gap(T_CYC); access(1'b0, 1'b1, 8'hFF, 8'h00, 1'b0);  // write ignores late_rd
    wait_gap(T_CYC); access(1'b1, 1'b1, 8'hFF, 8'h00, 1'b0);
    // R9: start during a running sequence is dropped
    wait_gap(T_CYC); access(1'b1, 1'b0, 8'h07, 8'h00, 1'b1);
    repeat (3) begin
      chk(ras_n && !mfc, "R9", "no second sequence after busy poke", int'(ras_n), 1);
      @(negedge clk);
    end
    // R9: last forbidden edge ignored, first allowed edge accepted
    wait_gap(T_CYC - 1);
    start = 1'b1; rw = 1'b0; mar = 8'h90; mdr_in = 8'h11;
    @(negedge clk);
    start = 1'b0;
    chk(ras_n && s_ras[0], "R9", "start inside cycle window ignored", int'(ras_n), 1);
    access(1'b1, 1'b1, 8'h90, 8'h00, 1'b0);
    chk(dmem[8'h90] == ref_mem[8'h90], "R9", "ignored write left memory alone",
        int'(dmem[8'h90]), int'(ref_mem[8'h90]));
    repeat (4) @(negedge clk);
    chk(q.size() == 0, "R7", "every request completed", q.size(), 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule